// File: doc/BRIEF.md
# Vector Length Setup Unit

This unit sits in the decode stage of a vector-capable core. It looks at the 12-bit length-type field carried in an instruction prefix, together with a source register index and value, and produces the vector length (VL) and maximum vector length (MVL) that the rest of the pipeline applies to that instruction. It keeps its own small prefix context: a local VL, a local MVL and local source and destination element offsets. It also accepts the global VL/MVL held elsewhere in the core.

An all-zero field means the instruction runs under the global context and the global offsets. If no global VL has been set, that is scalar operation. Any non-zero field selects the prefix context. Depending on two flag bits, the instruction then either reuses the stored local length or sets a new one. Setting a length can write the result back to an integer register. A requested maximum beyond the configured limit raises an illegal-instruction trap that leaves all state untouched. The element loop engine outside drives step pulses that advance the local offsets.

Top module: `vl_setup_unit`

## Requirements
- R1: After reset the local VL and MVL are 1, both local offsets are 0, and `wr_en_o` and `trap_o` are low.
- R2: When the field is 12'h000 and `glb_set_i` is high, `eff_vl_o`/`eff_mvl_o` equal `glb_vl_i`/`glb_mvl_i`.
- R3: When the field is 12'h000 and `glb_set_i` is low, `eff_vl_o` and `eff_mvl_o` are both 1 (scalar).
- R4: Immediate mode is bit 11 = 1 and bit 0 = 1. The requested maximum is bits [5:1] and the destination index is bits [10:6]. With `rs1_idx_i` = 0, VL equals the requested maximum.
- R5: In a set mode with `rs1_idx_i` non-zero, VL is the smaller of `rs1_val_i` (unsigned) and the requested maximum.
- R6: In immediate mode, a requested maximum above `VL_LIMIT` raises `trap_o` in the same cycle as `valid_i`. It produces no register write and no change to local VL, MVL or offsets.
- R7: An accepted set-mode instruction drives `wr_en_o` high for that one cycle, with `wr_idx_o` = bits [10:6] and `wr_data_o` = the computed VL. This happens only when that index is non-zero.
- R8: An accepted set-mode instruction loads local VL/MVL on the next clock edge. Reuse mode (bit 11 = 0, field non-zero) presents the stored local VL/MVL and writes and changes nothing.
- R9: Keep mode is bit 11 = 1 and bit 0 = 0. The requested maximum is the current local MVL, bits [5:1] are ignored, and MVL keeps its value.
- R10: An accepted set-mode instruction clears both local offsets on the next edge, overriding any step pulse in the same cycle.
- R11: Without an accepted set, each `src_step_i`/`dst_step_i` pulse advances its local offset by one, modulo 2^`OFFS_W`.
- R12: `offs_local_o` is high exactly when the field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Decoded instruction present this cycle |
| vltype_i | input | 12 | Length-type field from the prefix |
| rs1_idx_i | input | 5 | Source register index |
| rs1_val_i | input | DATA_W | Source register value |
| glb_vl_i | input | VL_W | Global VL |
| glb_mvl_i | input | VL_W | Global MVL |
| glb_set_i | input | 1 | Global VL has been set |
| src_step_i | input | 1 | Advance local source offset |
| dst_step_i | input | 1 | Advance local destination offset |
| eff_vl_o | output | VL_W | Effective VL for this instruction |
| eff_mvl_o | output | VL_W | Effective MVL for this instruction |
| offs_local_o | output | 1 | Local offsets apply (1) or global (0) |
| src_offs_o | output | OFFS_W | Local source offset |
| dst_offs_o | output | OFFS_W | Local destination offset |
| wr_en_o | output | 1 | Register write enable |
| wr_idx_o | output | 5 | Register write index |
| wr_data_o | output | DATA_W | Register write value |
| trap_o | output | 1 | Illegal-instruction trap |

## Verification
Two functions can land in the same cycle: an accepted length set that clears the local offsets, and a step pulse from the loop engine that advances them. The bench drives step pulses together with set-mode decodes, both in directed cycles and throughout a long random run. It judges the offsets in the following cycle against a behavioural model in which the clear wins. The same run also pairs trapping decodes with step pulses, where the step must still take effect while VL and MVL hold.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;
  localparam int FIELD_W = 12;
  localparam int IDX_W   = 5;
  localparam int IMM_W   = 5;

  typedef enum logic [1:0] {
    MODE_GLOBAL,
    MODE_REUSE,
    MODE_SET_IMM,
    MODE_SET_KEEP
  } vl_mode_e;

  typedef struct packed {
    vl_mode_e          mode;
    logic [IDX_W-1:0]  rd_idx;
    logic [IMM_W-1:0]  imm;
  } vl_dec_t;
endpackage

// File: rtl/vlsu_field_dec.sv
module vlsu_field_dec
  import vlsu_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  output vl_dec_t            dec_o
);
  always_comb begin
    dec_o.rd_idx = field_i[10:6];
    dec_o.imm    = field_i[5:1];
    if (field_i == '0)      dec_o.mode = MODE_GLOBAL;
    else if (!field_i[11])  dec_o.mode = MODE_REUSE;
    else if (field_i[0])    dec_o.mode = MODE_SET_IMM;
    else                    dec_o.mode = MODE_SET_KEEP;
  end
endmodule

// File: rtl/vlsu_len_calc.sv
module vlsu_len_calc
  import vlsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int VL_LIMIT = 24,
  parameter int VL_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  vl_dec_t           dec_i,
  input  logic [IDX_W-1:0]  rs1_idx_i,
  input  logic [DATA_W-1:0] rs1_val_i,
  input  logic [VL_W-1:0]   cur_mvl_i,
  output logic [VL_W-1:0]   new_vl_o,
  output logic [VL_W-1:0]   new_mvl_o,
  output logic              accept_o,
  output logic              trap_o
);
  localparam int REQ_W = (VL_W > IMM_W) ? VL_W : IMM_W;

  logic [REQ_W-1:0]  req_max;
  logic [DATA_W-1:0] req_ext;
  logic [DATA_W-1:0] vl_ext;
  logic              is_set;

  assign is_set  = (dec_i.mode == MODE_SET_IMM) || (dec_i.mode == MODE_SET_KEEP);
  assign req_max = (dec_i.mode == MODE_SET_IMM) ? REQ_W'(dec_i.imm) : REQ_W'(cur_mvl_i);
  assign req_ext = DATA_W'(req_max);

  // only the immediate can exceed the limit; the stored MVL was checked on load
  assign trap_o   = valid_i && (dec_i.mode == MODE_SET_IMM) && (req_max > REQ_W'(VL_LIMIT));
  assign accept_o = valid_i && is_set && !trap_o;

  always_comb begin
    if (rs1_idx_i == '0)          vl_ext = req_ext;
    else if (rs1_val_i < req_ext) vl_ext = rs1_val_i;
    else                          vl_ext = req_ext;
  end

  assign new_vl_o  = VL_W'(vl_ext);
  assign new_mvl_o = VL_W'(req_max);

  // R4
  x0_takes_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && rs1_idx_i == '0) |-> (new_vl_o == new_mvl_o));
  // R5
  vl_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && rs1_idx_i != '0) |-> (DATA_W'(new_vl_o) <= rs1_val_i && new_vl_o <= new_mvl_o));
  // R6
  trap_only_imm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (valid_i && dec_i.mode == MODE_SET_IMM && !accept_o));
endmodule

// File: rtl/vlsu_ctx_regs.sv
module vlsu_ctx_regs #(
  parameter int VL_W   = 5,
  parameter int OFFS_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   mvl_i,
  input  logic              src_step_i,
  input  logic              dst_step_i,
  output logic [VL_W-1:0]   vl_o,
  output logic [VL_W-1:0]   mvl_o,
  output logic [OFFS_W-1:0] src_offs_o,
  output logic [OFFS_W-1:0] dst_offs_o
);
  logic [1:0]              step;
  logic [1:0][OFFS_W-1:0]  offs_q;

  assign step = {dst_step_i, src_step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_o  <= VL_W'(1);
      mvl_o <= VL_W'(1);
    end else if (load_i) begin
      vl_o  <= vl_i;
      mvl_o <= mvl_i;
    end
  end

  // index 0 = source, 1 = destination; load clears before step
  for (genvar g = 0; g < 2; g++) begin : g_offs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      offs_q[g] <= '0;
      else if (load_i)  offs_q[g] <= '0;
      else if (step[g]) offs_q[g] <= offs_q[g] + OFFS_W'(1);
    end
  end

  assign src_offs_o = offs_q[0];
  assign dst_offs_o = offs_q[1];

  // R8
  ctx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(vl_o) && $stable(mvl_o)));
  // R10
  offs_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (src_offs_o == '0 && dst_offs_o == '0));
  // R11
  src_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && src_step_i) |=> (src_offs_o == $past(src_offs_o) + OFFS_W'(1)));
  // R11
  dst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dst_step_i) |=> $stable(dst_offs_o));
endmodule

// File: rtl/vl_setup_unit.sv
module vl_setup_unit
  import vlsu_pkg::*;
#(
  parameter int  DATA_W   = 32,
  parameter int  VL_LIMIT = 24,
  localparam int VL_W     = $clog2(VL_LIMIT + 1),
  localparam int OFFS_W   = VL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [11:0]        vltype_i,
  input  logic [4:0]         rs1_idx_i,
  input  logic [DATA_W-1:0]  rs1_val_i,
  input  logic [VL_W-1:0]    glb_vl_i,
  input  logic [VL_W-1:0]    glb_mvl_i,
  input  logic               glb_set_i,
  input  logic               src_step_i,
  input  logic               dst_step_i,
  output logic [VL_W-1:0]    eff_vl_o,
  output logic [VL_W-1:0]    eff_mvl_o,
  output logic               offs_local_o,
  output logic [OFFS_W-1:0]  src_offs_o,
  output logic [OFFS_W-1:0]  dst_offs_o,
  output logic               wr_en_o,
  output logic [4:0]         wr_idx_o,
  output logic [DATA_W-1:0]  wr_data_o,
  output logic               trap_o
);
  vl_dec_t         dec;
  logic [VL_W-1:0] new_vl, new_mvl, ctx_vl, ctx_mvl;
  logic            accept;

  vlsu_field_dec i_dec (
    .field_i (vltype_i),
    .dec_o   (dec)
  );

  vlsu_len_calc #(
    .DATA_W   (DATA_W),
    .VL_LIMIT (VL_LIMIT),
    .VL_W     (VL_W)
  ) i_calc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .dec_i     (dec),
    .rs1_idx_i (rs1_idx_i),
    .rs1_val_i (rs1_val_i),
    .cur_mvl_i (ctx_mvl),
    .new_vl_o  (new_vl),
    .new_mvl_o (new_mvl),
    .accept_o  (accept),
    .trap_o    (trap_o)
  );

  vlsu_ctx_regs #(
    .VL_W   (VL_W),
    .OFFS_W (OFFS_W)
  ) i_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .vl_i       (new_vl),
    .mvl_i      (new_mvl),
    .src_step_i (src_step_i),
    .dst_step_i (dst_step_i),
    .vl_o       (ctx_vl),
    .mvl_o      (ctx_mvl),
    .src_offs_o (src_offs_o),
    .dst_offs_o (dst_offs_o)
  );

  always_comb begin
    if (dec.mode == MODE_GLOBAL) begin
      eff_vl_o  = glb_set_i ? glb_vl_i  : VL_W'(1);
      eff_mvl_o = glb_set_i ? glb_mvl_i : VL_W'(1);
    end else if (accept) begin
      eff_vl_o  = new_vl;
      eff_mvl_o = new_mvl;
    end else begin
      eff_vl_o  = ctx_vl;
      eff_mvl_o = ctx_mvl;
    end
  end

  assign offs_local_o = (dec.mode != MODE_GLOBAL);
  assign wr_en_o      = accept && (dec.rd_idx != '0);
  assign wr_idx_o     = dec.rd_idx;
  assign wr_data_o    = DATA_W'(new_vl);

  // R12
  offs_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offs_local_o == (vltype_i != '0));
  // R6
  trap_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !wr_en_o);
  // R7
  write_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (valid_i && vltype_i[11] && wr_idx_o != '0 && wr_data_o == DATA_W'(eff_vl_o)));
  // R3
  scalar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vltype_i == '0 && !glb_set_i) |-> (eff_vl_o == VL_W'(1) && eff_mvl_o == VL_W'(1)));
endmodule

// File: tb/test_vl_setup_unit.sv
`timescale 1ns/1ps
module test_vl_setup_unit;
  localparam int LIMIT = 24;
  localparam int DW    = 32;
  localparam int VW    = $clog2(LIMIT + 1);
  localparam int OMOD  = 1 << VW;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          valid = 0, gset = 0, sstep = 0, dstep = 0;
  logic [11:0]   vltype = '0;
  logic [4:0]    rs1_idx = '0;
  logic [DW-1:0] rs1_val = '0;
  logic [VW-1:0] gvl = '0, gmvl = '0;
  logic [VW-1:0] eff_vl, eff_mvl, so, dso;
  logic          offs_local, wr_en, trap;
  logic [4:0]    wr_idx;
  logic [DW-1:0] wr_data;

  int n_tests = 0, n_fail = 0;
  int m_vl = 1, m_mvl = 1, m_so = 0, m_do = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vl_setup_unit #(.DATA_W(DW), .VL_LIMIT(LIMIT)) i_vl_setup_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .vltype_i(vltype),
    .rs1_idx_i(rs1_idx), .rs1_val_i(rs1_val), .glb_vl_i(gvl), .glb_mvl_i(gmvl),
    .glb_set_i(gset), .src_step_i(sstep), .dst_step_i(dstep),
    .eff_vl_o(eff_vl), .eff_mvl_o(eff_mvl), .offs_local_o(offs_local),
    .src_offs_o(so), .dst_offs_o(dso), .wr_en_o(wr_en), .wr_idx_o(wr_idx),
    .wr_data_o(wr_data), .trap_o(trap)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // inputs are already driven; check at negedge, then advance model at posedge
  task automatic cycle();
    int ev, em, req, cv, rd, imm;
    bit acc, trp;
    string tag;
    @(negedge clk);
    rd = int'(vltype[10:6]);
    imm = int'(vltype[5:1]);
    acc = 0; trp = 0; cv = 0; req = 0;
    if (vltype == 12'h000) begin
      tag = gset ? "R2" : "R3";
      ev = gset ? int'(gvl) : 1;
      em = gset ? int'(gmvl) : 1;
    end else if (!vltype[11]) begin
      tag = "R8";
      ev = m_vl; em = m_mvl;
    end else begin
      req = vltype[0] ? imm : m_mvl;
      trp = valid && vltype[0] && (imm > LIMIT);
      acc = valid && !trp;
      if (rs1_idx == 0) cv = req;
      else if (rs1_val < DW'(req)) cv = int'(rs1_val);
      else cv = req;
      tag = !vltype[0] ? "R9" : (trp ? "R6" : (rs1_idx == 0 ? "R4" : "R5"));
      if (acc) begin ev = cv; em = req; end
      else begin ev = m_vl; em = m_mvl; end
    end
    chk(tag, "eff_vl", eff_vl, ev);
    chk(tag, "eff_mvl", eff_mvl, em);
    chk("R12", "offs_local", offs_local, vltype != 0);
    chk("R6", "trap", trap, trp);
    chk("R7", "wr_en", wr_en, acc && rd != 0);
    if (acc && rd != 0) begin
      chk("R7", "wr_idx", wr_idx, rd);
      chk("R7", "wr_data", wr_data, cv);
    end
    @(posedge clk);
    if (acc) begin
      m_vl = cv; m_mvl = req; m_so = 0; m_do = 0;
    end else begin
      if (sstep) m_so = (m_so + 1) % OMOD;
      if (dstep) m_do = (m_do + 1) % OMOD;
    end
    #1;
    chk(acc ? "R10" : "R11", "src_offs", so, m_so);
    chk(acc ? "R10" : "R11", "dst_offs", dso, m_do);
  endtask

  task automatic drive(bit v, logic [11:0] f, int ri, logic [DW-1:0] rv,
                       bit ss = 0, bit ds = 0);
    valid = v; vltype = f; rs1_idx = 5'(ri); rs1_val = rv; sstep = ss; dstep = ds;
    cycle();
  endtask

  function automatic logic [11:0] fset(bit imm_mode, int rd, int imm);
    return {1'b1, 5'(rd), 5'(imm), imm_mode};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    vltype = 12'h002;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "local vl", eff_vl, 1);
    chk("R1", "local mvl", eff_mvl, 1);
    chk("R1", "src_offs", so, 0);
    chk("R1", "dst_offs", dso, 0);
    chk("R1", "wr_en", wr_en, 0);
    chk("R1", "trap", trap, 0);
    @(posedge clk); #1;

    gvl = 5'd7; gmvl = 5'd12; gset = 1;
    drive(1, 12'h000, 0, 0);                 // R2
    gset = 0;
    drive(1, 12'h000, 3, 50);                // R3 scalar
    drive(1, fset(1, 3, 16), 0, 99);         // R4 vl=16, write x3
    drive(1, fset(1, 0, 20), 5, 9);          // R5 vl=9, rd=x0 no write
    drive(1, 12'h002, 0, 0);                 // R8 reuse 9/20
    drive(0, 12'h002, 0, 0, 1, 1);           // R11
    drive(0, 12'h004, 0, 0, 1, 0);           // R11
    drive(1, fset(0, 4, 31), 2, 100, 1, 1);  // R9 keep mvl 20, R10 clear wins
    drive(1, fset(1, 6, 25), 0, 0, 1, 0);    // R6 trap, step still counts
    drive(1, 12'h7fe, 0, 0);                 // R8 still 20/20
    drive(1, fset(1, 1, 24), 0, 0);          // R6 boundary, no trap
    drive(1, fset(1, 2, 0), 0, 0);           // R4 zero max
    drive(1, fset(0, 5, 3), 7, 32'hffff_ffff); // R9 with mvl 0

    for (int i = 0; i < 600; i++) begin
      int k;
      logic [DW-1:0] rv;
      logic [11:0] f;
      k = $urandom_range(0, 9);
      gvl = 5'($urandom); gmvl = 5'($urandom); gset = 1'($urandom);
      rv = ($urandom_range(0, 3) == 0) ? DW'($urandom) : DW'($urandom_range(0, 40));
      case (k)
        0: f = 12'h000;
        1, 2: f = {1'b0, 11'($urandom_range(1, 2047))};
        3, 4, 5, 6: f = fset(1, $urandom_range(0, 31), $urandom_range(0, 31));
        default: f = fset(0, $urandom_range(0, 31), $urandom_range(0, 31));
      endcase
      drive(1'($urandom_range(0, 4) != 0), f, $urandom_range(0, 3) == 0 ? 0 : $urandom_range(1, 31),
            rv, 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule